// File: doc/BRIEF.md
# Temperature-Adaptive DRAM Refresh Controller

This block paces refresh requests for a DRAM array so that the refresh rate follows the temperature actually measured on the die. It does not assume the worst-case rating. Several on-die sensors each present a temperature code and a valid flag. The controller registers these inputs and takes the hottest valid reading. It then looks that reading up in a programmable curve of eight temperature bands, each band carrying its own refresh interval in clock cycles. Hotter bands are programmed with shorter intervals, because retention time falls off steeply as temperature climbs.

A free-running cycle counter issues a refresh each time it reaches the interval in force. A rise in temperature cuts the running countdown at once. A drop in temperature is applied only when the current period ends. When no sensor is valid, the controller falls back to a worst-case interval that is fixed by a parameter.

Requests use a level-and-acknowledge handshake with the refresh circuit. Refreshes that fall due before earlier ones have been acknowledged are counted in a backlog, and they are then served back to back.

Top module: `thermal_refresh_ctrl`

## Requirements
- R1: After reset, refresh_req is low, backlog is 0 and cur_interval equals WORST_IVAL. Every band interval resets to WORST_IVAL, and threshold k resets to k*2^TW/NBANDS.
- R2: The hottest reading among valid sensors selects band k, the largest k with reading >= threshold k. A reading below threshold 0 selects band 0. The target interval is the interval of that band.
- R3: A sensor whose valid bit is 0 is left out of the maximum. If no sensor is valid, the target interval is WORST_IVAL.
- R4: In steady state, refresh requests begin exactly cur_interval cycles apart.
- R5: A sensor change that lowers the target interval sets cur_interval two clock edges after the input changes. If at least that many cycles have already elapsed in the current period, the refresh issues on that same edge.
- R6: A sensor change that raises the target interval leaves cur_interval and the running period unchanged until the next refresh. From that refresh on, the new interval applies.
- R7: A refresh that falls due while refresh_req is still unacknowledged increments backlog, and refresh_req stays high. The backlog saturates at 2^PW-1.
- R8: Each cycle with refresh_done high while refresh_req is high retires one request. refresh_req stays high over consecutive cycles until the backlog reaches 0.
- R9: A cfg_we write sets threshold cfg_idx to cfg_thresh and interval cfg_idx to cfg_interval. The whole write is ignored if cfg_interval is 0, or if the threshold would not stay strictly above threshold cfg_idx-1 and strictly below threshold cfg_idx+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_code | input | NSENS*TW | Sensor temperature codes, sensor s at bits [s*TW +: TW] |
| temp_valid | input | NSENS | Per-sensor valid flags |
| cfg_we | input | 1 | Curve write strobe |
| cfg_idx | input | log2(NBANDS) | Band index of the write |
| cfg_thresh | input | TW | Lower temperature bound of the band |
| cfg_interval | input | IW | Refresh interval of the band in cycles |
| refresh_done | input | 1 | Acknowledge from the refresh circuit |
| refresh_req | output | 1 | Refresh request, held until acknowledged |
| backlog | output | PW | Outstanding refresh requests |
| cur_interval | output | IW | Interval currently in force |

## Verification
The lookup is swept over every temperature code. The sweep runs once upward, where each band change must appear within two edges, and once downward, where band changes may only appear after a period ends. The two sweeps separate the immediate tightening from the deferred relaxing. Mixed sensor readings with chosen valid masks show that only valid sensors feed the maximum and that an all-invalid set falls back to the worst case. Period measurements around a temperature step separate a shortened countdown from a deferred lengthening. Withholding the acknowledge, including past saturation, and then releasing it exercises the backlog and the back-to-back reissue. Out-of-order threshold writes and zero-interval writes are read back through the lookup.

// File: rtl/thermal_refresh_ctrl.sv
module thermal_refresh_ctrl #(
  parameter int NSENS      = 4,
  parameter int TW         = 8,
  parameter int IW         = 16,
  parameter int NBANDS     = 8,
  parameter int PW         = 4,
  parameter int WORST_IVAL = 4096,
  localparam int BW = $clog2(NBANDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSENS*TW-1:0] temp_code,
  input  logic [NSENS-1:0]    temp_valid,
  input  logic                cfg_we,
  input  logic [BW-1:0]       cfg_idx,
  input  logic [TW-1:0]       cfg_thresh,
  input  logic [IW-1:0]       cfg_interval,
  input  logic                refresh_done,
  output logic                refresh_req,
  output logic [PW-1:0]       backlog,
  output logic [IW-1:0]       cur_interval
);
  localparam logic [IW-1:0] WORST = IW'(WORST_IVAL);
  localparam logic [PW-1:0] BMAX  = '1;
  localparam int            STEP  = (2 ** TW) / NBANDS;

  logic [NSENS*TW-1:0] temp_q;
  logic [NSENS-1:0]    valid_q;
  logic [TW-1:0]       thr  [NBANDS];
  logic [IW-1:0]       ival [NBANDS];
  logic [TW-1:0]       hot;
  logic                any_valid;
  logic [BW-1:0]       band;
  logic [IW-1:0]       target, eff;
  logic [IW-1:0]       elapsed;
  logic                due;
  logic [BW-1:0]       idx_up, idx_dn;
  logic                cfg_ok;

  always_comb begin
    hot = '0;
    any_valid = 1'b0;
    for (int s = 0; s < NSENS; s++)
      if (valid_q[s]) begin
        any_valid = 1'b1;
        if (temp_q[s*TW +: TW] > hot) hot = temp_q[s*TW +: TW];
      end
    band = '0;
    for (int k = 0; k < NBANDS; k++)
      if (hot >= thr[k]) band = BW'(k);
  end

  assign target = any_valid ? ival[band] : WORST;
  assign eff    = (target < cur_interval) ? target : cur_interval;
  assign due    = ({1'b0, elapsed} + 1'b1) >= {1'b0, eff};

  assign idx_up = cfg_idx + 1'b1;
  assign idx_dn = cfg_idx - 1'b1;
  assign cfg_ok = (cfg_interval != '0)
               && (cfg_idx == '0 || cfg_thresh > thr[idx_dn])
               && (cfg_idx == BW'(NBANDS - 1) || cfg_thresh < thr[idx_up]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      temp_q  <= '0;
      valid_q <= '0;
      for (int k = 0; k < NBANDS; k++) begin
        thr[k]  <= TW'(k * STEP);
        ival[k] <= WORST;
      end
    end else begin
      temp_q  <= temp_code;
      valid_q <= temp_valid;
      if (cfg_we && cfg_ok) begin
        thr[cfg_idx]  <= cfg_thresh;
        ival[cfg_idx] <= cfg_interval;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      elapsed      <= '0;
      cur_interval <= WORST;
    end else if (due) begin
      elapsed      <= '0;
      cur_interval <= target;
    end else begin
      elapsed <= elapsed + 1'b1;
      if (target < cur_interval) cur_interval <= target;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) backlog <= '0;
    else case ({due, refresh_done && refresh_req})
      2'b10:   if (backlog != BMAX) backlog <= backlog + 1'b1;
      2'b01:   backlog <= backlog - 1'b1;
      default: backlog <= backlog;
    endcase

  assign refresh_req = backlog != '0;
endmodule

module thermal_refresh_ctrl_chk #(
  parameter int IW = 16,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          refresh_req,
  input logic          refresh_done,
  input logic [PW-1:0] backlog,
  input logic [IW-1:0] cur_interval,
  input logic [IW-1:0] elapsed
);
  assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_done) |=> refresh_req);
  assert_no_backlog_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(backlog) == '1) |-> (backlog >= $past(backlog) - 1'b1));
  assert_backlog_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && refresh_done && backlog == 1) |=> (backlog <= 1));
  assert_relax_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_interval > $past(cur_interval)) |-> (elapsed == '0));
  assert_count_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (elapsed < cur_interval));
  assert_interval_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_interval != '0));
endmodule

bind thermal_refresh_ctrl thermal_refresh_ctrl_chk #(.IW(IW), .PW(PW)) i_chk (
  .clk(clk), .rst_n(rst_n), .refresh_req(refresh_req), .refresh_done(refresh_done),
  .backlog(backlog), .cur_interval(cur_interval), .elapsed(elapsed));

// File: tb/test_thermal_refresh_ctrl.sv
module test_thermal_refresh_ctrl;
  localparam int NS = 4, TW = 8, IW = 12, NB = 8, PW = 4, WORST = 64;

  logic clk = 0, rst_n = 0;
  logic [NS*TW-1:0] temp_code = '0;
  logic [NS-1:0] temp_valid = '0;
  logic cfg_we = 0;
  logic [2:0] cfg_idx = '0;
  logic [TW-1:0] cfg_thresh = '0;
  logic [IW-1:0] cfg_interval = '0;
  logic ack_en = 1;
  logic refresh_req, refresh_done;
  logic [PW-1:0] backlog;
  logic [IW-1:0] cur_interval;
  int checks = 0, fails = 0, cyc = 0;

  assign refresh_done = ack_en & refresh_req;
  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  thermal_refresh_ctrl #(.NSENS(NS), .TW(TW), .IW(IW), .NBANDS(NB), .PW(PW),
    .WORST_IVAL(WORST)) i_thermal_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .temp_valid(temp_valid),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_thresh(cfg_thresh),
    .cfg_interval(cfg_interval), .refresh_done(refresh_done),
    .refresh_req(refresh_req), .backlog(backlog), .cur_interval(cur_interval));

  function automatic int exp_ival(int t);
    int b = t / 30;
    if (b > 7) b = 7;
    return 8 * (8 - b);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_all(int t);
    temp_valid = '1;
    for (int s = 0; s < NS; s++) temp_code[s*TW +: TW] = TW'(t);
  endtask

  task automatic write(int idx, int th, int iv);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_thresh = TW'(th); cfg_interval = IW'(iv);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic next_rise(output int at);
    logic p = refresh_req;
    forever begin
      @(negedge clk);
      if (refresh_req && !p) break;
      p = refresh_req;
    end
    at = cyc;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int a, b, n;
    ticks(2);
    check(refresh_req == 0 && backlog == 0, "R1 req/backlog", backlog, 0);
    check(cur_interval == WORST, "R1 interval", cur_interval, WORST);
    rst_n = 1;
    set_all(250);
    ticks(3);
    check(cur_interval == WORST, "R1 reset table", cur_interval, WORST);
    for (int k = 0; k < NB; k++) write(k, 30 * k, 8 * (8 - k));

    for (int t = 0; t < 256; t += 3) begin
      set_all(0); ticks(70);
      set_all(t); ticks(2);
      check(cur_interval == exp_ival(t), "R2 R5 up sweep", cur_interval, exp_ival(t));
    end
    set_all(255); ticks(3);
    for (int t = 255; t >= 0; t -= 5) begin
      set_all(t); ticks(70);
      check(cur_interval == exp_ival(t), "R2 R6 down sweep", cur_interval, exp_ival(t));
    end

    temp_code = {8'd200, 8'd50, 8'd100, 8'd10};
    temp_valid = 4'b0111; ticks(70);
    check(cur_interval == 40, "R3 masked max", cur_interval, 40);
    temp_valid = 4'b1111; ticks(3);
    check(cur_interval == 16, "R2 max of valid", cur_interval, 16);
    temp_valid = 4'b0000; ticks(70);
    check(cur_interval == WORST, "R3 all invalid", cur_interval, WORST);

    set_all(100); ticks(70);
    next_rise(a); next_rise(b);
    check(b - a == 40, "R4 period", b - a, 40);

    set_all(0); ticks(70);
    next_rise(a); ticks(40);
    set_all(220); ticks(2);
    check(refresh_req == 1 && cur_interval == 8, "R5 immediate fire", cur_interval, 8);

    set_all(0); ticks(70);
    next_rise(a); ticks(2);
    set_all(130); ticks(2);
    check(cur_interval == 32 && refresh_req == 0, "R5 shorten", cur_interval, 32);
    next_rise(b);
    check(b - a == 32, "R5 shortened period", b - a, 32);

    set_all(220); ticks(70);
    next_rise(a); ticks(1);
    set_all(0); ticks(3);
    check(cur_interval == 8, "R6 deferred", cur_interval, 8);
    next_rise(b);
    check(b - a == 8, "R6 old period kept", b - a, 8);
    check(cur_interval == 64, "R6 new interval", cur_interval, 64);

    set_all(220); ticks(70);
    next_rise(a); ticks(1);
    ack_en = 0;
    next_rise(a);
    check(backlog == 1, "R7 first", backlog, 1);
    ticks(8);
    check(backlog == 2 && refresh_req, "R7 inc", backlog, 2);
    ticks(8);
    check(backlog == 3, "R7 inc again", backlog, 3);
    ack_en = 1;
    n = 0;
    while (refresh_req) begin n++; @(negedge clk); end
    check(n == 3, "R8 back to back", n, 3);
    ack_en = 0; ticks(200);
    check(backlog == 15, "R7 saturate", backlog, 15);
    ack_en = 1; ticks(20);
    check(backlog == 0 || backlog == 1, "R8 drained", backlog, 0);

    write(3, 200, 5);
    set_all(0); ticks(70); set_all(95); ticks(3);
    check(cur_interval == 40, "R9 order reject", cur_interval, 40);
    write(7, 210, 0);
    set_all(220); ticks(3);
    check(cur_interval == 8, "R9 zero reject", cur_interval, 8);
    write(3, 95, 36);
    set_all(0); ticks(70); set_all(95); ticks(3);
    check(cur_interval == 36, "R9 accept", cur_interval, 36);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule